// File: doc/BRIEF.md
# Mailbox Send Channel Engine

The engine delivers fixed-size command messages from a host to a coprocessor through a mailbox held in shared RAM. Each of the seven channels owns one 32-byte message slot and one state byte in that RAM. The slot can hold only one message at a time, so the engine keeps a short pending queue for each channel. A message is copied into the slot, the state byte is marked NEW and a doorbell is pulsed. The coprocessor moves the state on to COMPLETE and leaves its reply in the same slot.

When the shared completion interrupt is raised, the engine clears it and scans every channel's state byte. For each channel found COMPLETE, it returns the state to IDLE and reads the reply back out of the slot. It then presents the reply with its channel number and launches the next queued message for that channel. Requesters see a one-cycle response for each request they hand over: accepted, busy (queue full) or rejected (bad channel or length).

Top module: `mbox_send_engine`

## Requirements
- R1: After reset no RAM access, doorbell, interrupt clear, reply or response is active, and `req_ready` is high.
- R2: State byte encoding is IDLE=0, NEW=1, RCVD=2, COMPLETE=3. The state byte of channel c sits at address c. Byte i of the slot of channel c sits at address 32 + 32*c + i. A RAM read returns data one cycle after `mem_re`, and no cycle both reads and writes.
- R3: A request naming channel 7, or with a length above 32, gets response code 2 (reject) and causes no RAM write and no doorbell.
- R4: An accepted request gets response code 0. If its channel queue was empty and the state byte reads IDLE, the engine writes all 32 slot bytes, with bytes at or beyond the length written as zero. It then writes NEW to the state byte, and in the following cycle it pulses `doorbell`.
- R5: If the state byte does not read IDLE when an accepted request finds its queue empty, the engine writes nothing and holds the message in the queue.
- R6: Each channel queue holds four messages. A request to a full queue gets response code 1 (busy) and is dropped.
- R7: While idle with `int0` high, the engine pulses `int0_clr` and then reads the state byte of every channel in ascending order. It services only the channels that read COMPLETE and leaves the state bytes of all other channels unchanged.
- R8: Servicing a channel writes IDLE to its state byte and reads the 32 reply bytes from its slot. If a message was in flight on that channel, the engine presents the reply on `rep_data` with `rep_chan` for one cycle. A COMPLETE state with no message in flight is only cleared and presents no reply.
- R9: After servicing, the oldest queued message of that channel, if any, is launched as in R4 without rereading the state byte. Messages on one channel go out in the order in which they were accepted.
- R10: `rsp_valid` rises exactly one cycle after a request is accepted (`req_valid` and `req_ready` both high). `req_ready` is low whenever the engine is launching or scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can take a request this cycle |
| req_chan | input | 3 | Target channel |
| req_len | input | 6 | Message length in bytes |
| req_data | input | 256 | Message, byte i at bits 8i+7:8i |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 accepted, 1 busy, 2 rejected |
| mem_we | output | 1 | Shared RAM write strobe |
| mem_re | output | 1 | Shared RAM read strobe |
| mem_addr | output | 9 | Shared RAM byte address |
| mem_wdata | output | 8 | Shared RAM write data |
| mem_rdata | input | 8 | Shared RAM read data, one cycle after `mem_re` |
| doorbell | output | 1 | One-cycle pulse to the coprocessor |
| int0 | input | 1 | Send-completion interrupt level |
| int0_clr | output | 1 | One-cycle clear of `int0` |
| rep_valid | output | 1 | Reply strobe |
| rep_chan | output | 3 | Channel of the reply |
| rep_data | output | 256 | Reply bytes |

## Verification
The bench builds the engine with its default parameters: seven channels, a queue depth of four and 32-byte slots. With these values a 3-bit channel field can name the nonexistent channel 7, so the channel reject path is reachable. A queue can be filled within a few requests, which exposes the busy response, and a single completion event can find two channels COMPLETE beside one left in RCVD. The small depth also makes a stale COMPLETE, with no message in flight, cheap to set up. It shows both the held-message path and the FIFO order of successive launches.

// File: rtl/mbox_send_engine.sv
module mbox_send_engine #(
  parameter int NCH = 7,
  parameter int SLOT_BYTES = 32,
  parameter int DEPTH = 4,
  parameter int AW = 9,
  parameter int STATE_BASE = 0,
  parameter int SLOT_BASE = 32,
  localparam int CW = $clog2(NCH + 1),
  localparam int LW = $clog2(SLOT_BYTES + 2),
  localparam int MW = SLOT_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_chan,
  input  logic [LW-1:0] req_len,
  input  logic [MW-1:0] req_data,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          doorbell,
  input  logic          int0,
  output logic          int0_clr,
  output logic          rep_valid,
  output logic [CW-1:0] rep_chan,
  output logic [MW-1:0] rep_data
);
  localparam int IW = $clog2(SLOT_BYTES + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam int QN = NCH * DEPTH;
  localparam int QW = $clog2(QN + 1);
  localparam logic [7:0] ST_IDLE = 8'd0, ST_NEW = 8'd1, ST_DONE = 8'd3;
  localparam logic [1:0] RC_OK = 2'd0, RC_BUSY = 2'd1, RC_BAD = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK_RD, S_CHK, S_WSLOT, S_WSTATE, S_BELL,
    S_SCAN_RD, S_SCAN_EV, S_SVC, S_RREAD, S_REPLY
  } st_t;

  st_t st;
  logic [CW-1:0] ch;
  logic [IW-1:0] idx;
  logic scan;
  logic [MW-1:0] rbuf;
  logic [MW-1:0] q_mem [QN];
  logic [PW-1:0] head [NCH];
  logic [NW-1:0] cnt [NCH];
  logic [NCH-1:0] inflight;

  logic bad, full, acc, acc_ok, last_ch;
  logic [CW-1:0] rc;
  logic [QW-1:0] wr_slot, rd_slot;
  logic [MW-1:0] masked, head_msg;
  logic [NW-1:0] remain;
  logic [AW-1:0] state_addr, slot_addr;

  assign req_ready = (st == S_IDLE) && !int0;
  assign int0_clr  = (st == S_IDLE) && int0;
  assign doorbell  = (st == S_BELL);
  assign rep_valid = (st == S_REPLY) && inflight[ch];
  assign rep_chan  = ch;
  assign rep_data  = rbuf;

  assign bad     = (int'(req_chan) >= NCH) || (int'(req_len) > SLOT_BYTES);
  assign rc      = bad ? '0 : req_chan;
  assign full    = int'(cnt[rc]) == DEPTH;
  assign acc     = req_valid && req_ready;
  assign acc_ok  = acc && !bad && !full;
  assign last_ch = int'(ch) == NCH - 1;
  assign wr_slot = QW'(int'(rc) * DEPTH + int'(PW'(head[rc] + PW'(cnt[rc]))));
  assign rd_slot = QW'(int'(ch) * DEPTH + int'(head[ch]));
  assign head_msg = q_mem[rd_slot];
  assign remain  = cnt[ch] - NW'(inflight[ch]);
  assign state_addr = AW'(STATE_BASE + int'(ch));
  assign slot_addr  = AW'(SLOT_BASE + int'(ch) * SLOT_BYTES + int'(idx));

  always_comb begin
    for (int i = 0; i < SLOT_BYTES; i++)
      masked[i*8 +: 8] = (i < int'(req_len)) ? req_data[i*8 +: 8] : 8'd0;
  end

  always_comb begin
    mem_we = 1'b0;
    mem_re = 1'b0;
    mem_addr = state_addr;
    mem_wdata = 8'd0;
    case (st)
      S_CHK_RD, S_SCAN_RD: mem_re = 1'b1;
      S_WSLOT: begin
        mem_we = 1'b1;
        mem_addr = slot_addr;
        mem_wdata = head_msg[int'(idx)*8 +: 8];
      end
      S_WSTATE: begin
        mem_we = 1'b1;
        mem_wdata = ST_NEW;
      end
      S_SVC: begin
        mem_we = 1'b1;
        mem_wdata = ST_IDLE;
      end
      S_RREAD: begin
        mem_re = int'(idx) < SLOT_BYTES;
        mem_addr = slot_addr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (acc_ok) q_mem[wr_slot] <= masked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ch <= '0;
      idx <= '0;
      scan <= 1'b0;
      rbuf <= '0;
      rsp_valid <= 1'b0;
      rsp_code <= RC_OK;
      inflight <= '0;
      for (int c = 0; c < NCH; c++) begin
        head[c] <= '0;
        cnt[c] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (int0) begin
            scan <= 1'b1;
            ch <= '0;
            st <= S_SCAN_RD;
          end else if (req_valid) begin
            rsp_valid <= 1'b1;
            if (bad) rsp_code <= RC_BAD;
            else if (full) rsp_code <= RC_BUSY;
            else begin
              rsp_code <= RC_OK;
              cnt[rc] <= cnt[rc] + NW'(1);
              if (cnt[rc] == '0) begin
                ch <= rc;
                scan <= 1'b0;
                st <= S_CHK_RD;
              end
            end
          end
        end
        S_CHK_RD: st <= S_CHK;
        S_CHK: begin
          idx <= '0;
          st <= (mem_rdata == ST_IDLE) ? S_WSLOT : S_IDLE;
        end
        S_WSLOT: begin
          idx <= idx + IW'(1);
          if (int'(idx) == SLOT_BYTES - 1) st <= S_WSTATE;
        end
        S_WSTATE: begin
          inflight[ch] <= 1'b1;
          st <= S_BELL;
        end
        S_BELL: begin
          if (!scan || last_ch) st <= S_IDLE;
          else begin
            ch <= ch + CW'(1);
            st <= S_SCAN_RD;
          end
        end
        S_SCAN_RD: st <= S_SCAN_EV;
        S_SCAN_EV: begin
          if (mem_rdata == ST_DONE) st <= S_SVC;
          else if (last_ch) st <= S_IDLE;
          else begin
            ch <= ch + CW'(1);
            st <= S_SCAN_RD;
          end
        end
        S_SVC: begin
          idx <= '0;
          st <= S_RREAD;
        end
        S_RREAD: begin
          if (idx != '0) rbuf[(int'(idx) - 1)*8 +: 8] <= mem_rdata;
          if (int'(idx) == SLOT_BYTES) st <= S_REPLY;
          else idx <= idx + IW'(1);
        end
        S_REPLY: begin
          if (inflight[ch]) begin
            head[ch] <= head[ch] + PW'(1);
            cnt[ch] <= cnt[ch] - NW'(1);
            inflight[ch] <= 1'b0;
          end
          idx <= '0;
          if (remain != '0) st <= S_WSLOT;
          else if (last_ch) st <= S_IDLE;
          else begin
            ch <= ch + CW'(1);
            st <= S_SCAN_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_send_engine_chk.sv
module mbox_send_engine_chk #(
  parameter int NCH = 7,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [1:0]    rsp_code,
  input logic          mem_we,
  input logic          mem_re,
  input logic [7:0]    mem_wdata,
  input logic          doorbell,
  input logic          int0_clr,
  input logic          rep_valid,
  input logic [CW-1:0] rep_chan
);
  p_one_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_bell_after_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> $past(mem_we && mem_wdata == 8'd1));

  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_code != 2'd3);

  p_scan_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int0_clr |=> mem_re);

  p_reply_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid |-> (int'(rep_chan) < NCH) && !mem_we && !mem_re);

  p_rsp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

bind mbox_send_engine mbox_send_engine_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_we(mem_we), .mem_re(mem_re),
  .mem_wdata(mem_wdata), .doorbell(doorbell), .int0_clr(int0_clr),
  .rep_valid(rep_valid), .rep_chan(rep_chan)
);

// File: tb/mbox_send_engine_test.sv
module mbox_send_engine_test;
  localparam int PERIOD = 10;
  localparam int MW = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_chan = '0;
  logic [5:0] req_len = '0;
  logic [MW-1:0] req_data = '0;
  logic int0 = 1'b0;
  logic req_ready, rsp_valid, mem_we, mem_re, doorbell, int0_clr, rep_valid;
  logic [1:0] rsp_code;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [2:0] rep_chan;
  logic [MW-1:0] rep_data;

  logic [7:0] ram [512];
  int n_tests = 0, n_fail = 0, door_cnt = 0, rep_cnt = 0;
  logic [2:0] xs_ch [$];
  logic [MW-1:0] xs_dat [$];
  logic [2:0] xr_ch [$];
  logic [MW-1:0] xr_dat [$];

  always #(PERIOD/2) clk = ~clk;

  mbox_send_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_len(req_len), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .doorbell(doorbell), .int0(int0), .int0_clr(int0_clr),
    .rep_valid(rep_valid), .rep_chan(rep_chan), .rep_data(rep_data)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] pat(input int seed, input int len);
    logic [MW-1:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = (i < len) ? 8'(seed + i * 7) : 8'd0;
    return v;
  endfunction

  function automatic logic [MW-1:0] slot_img(input int c);
    logic [MW-1:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = ram[32 + 32*c + i];
    return v;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (doorbell) begin
        door_cnt++;
        if (xs_ch.size() == 0) chk(0, "R4 unexpected doorbell", 1, 0);
        else begin
          automatic logic [2:0] c = xs_ch.pop_front();
          automatic logic [MW-1:0] d = xs_dat.pop_front();
          chk(slot_img(int'(c)) == d, "R4 slot contents at doorbell", slot_img(int'(c)), d);
          chk(ram[c] == 8'd1, "R4 state NEW at doorbell", ram[c], 1);
        end
      end
      if (rep_valid) begin
        rep_cnt++;
        if (xr_ch.size() == 0) chk(0, "R8 unexpected reply", 1, 0);
        else begin
          automatic logic [2:0] c = xr_ch.pop_front();
          automatic logic [MW-1:0] d = xr_dat.pop_front();
          chk(rep_chan == c, "R8 reply channel", rep_chan, c);
          chk(rep_data == d, "R8 reply data", rep_data, d);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] c, input int len, input logic [MW-1:0] d,
                      input logic [1:0] exp_code, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_chan = c; req_len = 6'(len); req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    chk(rsp_valid && rsp_code == exp_code, tag, {rsp_valid, rsp_code}, {1'b1, exp_code});
    req_valid = 1'b0;
  endtask

  task automatic ring_int0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    int0 = 1'b1;
    #1;
    chk(int0_clr == 1'b1, "R7 int0_clr pulse", int0_clr, 1);
    @(posedge clk);
    @(negedge clk);
    int0 = 1'b0;
    chk(int0_clr == 1'b0, "R7 int0_clr single cycle", int0_clr, 0);
  endtask

  task automatic put_reply(input int c, input logic [MW-1:0] d);
    for (int i = 0; i < 32; i++) ram[32 + 32*c + i] = d[i*8 +: 8];
    ram[c] = 8'd3;
  endtask

  initial begin
    #(PERIOD * 150000);
    chk(0, "WATCHDOG expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int d0, r0;
    for (int i = 0; i < 512; i++) ram[i] = 8'd0;
    ram[3] = 8'd2;
    wait_cyc(3);
    chk(!mem_we && !mem_re && !doorbell && !rep_valid && !rsp_valid && !int0_clr,
        "R1 outputs quiet in reset", {mem_we, mem_re, doorbell, rep_valid, rsp_valid}, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    // R3 rejects
    send(3'd7, 4, pat(1, 4), 2'd2, "R3 channel 7 rejected");
    send(3'd0, 33, pat(2, 32), 2'd2, "R3 length 33 rejected");
    wait_cyc(50);
    chk(door_cnt == 0, "R3 no doorbell after reject", door_cnt, 0);
    chk(ram[0] == 8'd0 && slot_img(0) == '0, "R3 no RAM write after reject", slot_img(0), 0);

    // R4 full-length send on channel 2
    xs_ch.push_back(3'd2); xs_dat.push_back(pat(16, 32));
    send(3'd2, 32, pat(16, 32), 2'd0, "R4 accept ch2");
    wait_cyc(60);
    chk(door_cnt == 1, "R4 doorbell count ch2", door_cnt, 1);

    // R4 short message padded with zero
    xs_ch.push_back(3'd4); xs_dat.push_back(pat(80, 5));
    send(3'd4, 5, pat(80, 32), 2'd0, "R4 accept short ch4");
    wait_cyc(60);
    chk(door_cnt == 2, "R4 doorbell count ch4", door_cnt, 2);

    // R6 queue fill on channel 2 while in flight
    send(3'd2, 32, pat(40, 32), 2'd0, "R6 queue entry 2");
    send(3'd2, 32, pat(50, 32), 2'd0, "R6 queue entry 3");
    send(3'd2, 32, pat(60, 32), 2'd0, "R6 queue entry 4");
    send(3'd2, 32, pat(70, 32), 2'd1, "R6 full queue busy");
    wait_cyc(60);
    chk(door_cnt == 2, "R5 queued messages not written while busy", door_cnt, 2);

    // R7/R8/R9 service channels 2 and 4, channel 3 stays RCVD
    put_reply(2, pat(100, 32));
    put_reply(4, pat(140, 32));
    xr_ch.push_back(3'd2); xr_dat.push_back(pat(100, 32));
    xr_ch.push_back(3'd4); xr_dat.push_back(pat(140, 32));
    xs_ch.push_back(3'd2); xs_dat.push_back(pat(40, 32));
    ring_int0();
    wait_cyc(300);
    chk(rep_cnt == 2, "R8 two replies", rep_cnt, 2);
    chk(door_cnt == 3, "R9 next queued launched", door_cnt, 3);
    chk(ram[2] == 8'd1, "R9 ch2 back to NEW", ram[2], 1);
    chk(ram[4] == 8'd0, "R8 ch4 returned to IDLE", ram[4], 0);
    chk(ram[3] == 8'd2, "R7 non-complete ch3 untouched", ram[3], 2);

    // R5 held message, stale COMPLETE gives no reply
    ram[5] = 8'd2;
    d0 = door_cnt; r0 = rep_cnt;
    send(3'd5, 32, pat(200, 32), 2'd0, "R5 accept while RCVD");
    wait_cyc(60);
    chk(door_cnt == d0, "R5 held, no doorbell", door_cnt, d0);
    chk(ram[5] == 8'd2, "R5 state not touched", ram[5], 2);
    ram[5] = 8'd3;
    xs_ch.push_back(3'd5); xs_dat.push_back(pat(200, 32));
    ring_int0();
    wait_cyc(300);
    chk(rep_cnt == r0, "R8 stale COMPLETE no reply", rep_cnt, r0);
    chk(door_cnt == d0 + 1, "R9 held message launched", door_cnt, d0 + 1);
    chk(ram[5] == 8'd1, "R9 ch5 NEW after launch", ram[5], 1);

    // R9 FIFO order on channel 2
    put_reply(2, pat(33, 32));
    xr_ch.push_back(3'd2); xr_dat.push_back(pat(33, 32));
    xs_ch.push_back(3'd2); xs_dat.push_back(pat(50, 32));
    ring_int0();
    wait_cyc(300);
    chk(ram[2] == 8'd1, "R9 ch2 relaunched in order", ram[2], 1);
    send(3'd2, 32, pat(90, 32), 2'd0, "R6 space freed after service");

    chk(xs_ch.size() == 0, "R4 all expected sends seen", xs_ch.size(), 0);
    chk(xr_ch.size() == 0, "R8 all expected replies seen", xr_ch.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule